// File: doc/BRIEF.md
# Multiplexed-Address DRAM Cycle Decoder

This block is a clocked, synthesizable model of the control side of a multiplexed-address dynamic memory. It samples the active-low row strobe, column strobe, write enable and output enable on every clock and finds their edges. From the order of those edges it classifies each memory cycle. It latches the row and column halves of the address and picks the refresh row from either the address pins or an internal refresh counter. It also writes and reads a small storage array and decides when the data output is driven.

It serves as a checkable target for memory-controller benches. A controller drives the strobes as it would drive a real part. The bench then checks the data returned, the output-enable behaviour, the refresh row reported on every row-strobe cycle, and a one-cycle report of the cycle type at the end of each cycle. Cycle type codes on `cyc_type_o`: 1 read, 2 early write, 3 late write, 4 read-modify-write, 5 row-only refresh, 6 column-before-row refresh, 7 column-only.

Top module: `dram_cycle_decoder`

## Requirements
- R1: While `rst_ni` is low and after it is released, `dout_en_o`, `refr_stb_o` and `cyc_done_o` are 0 and the refresh counter is 0, so the first column-before-row refresh reports row 0.
- R2: A fall of `ras_ni` while `cas_ni` is high latches the row from `addr_i` and gives a one-cycle `refr_stb_o` with `refr_row_o` equal to that address. A row cycle with no column fall ends, at the rise of `ras_ni`, with a one-cycle `cyc_done_o` and type 5.
- R3: If `cas_ni` is already low when `ras_ni` falls, the cycle is a column-before-row refresh. `refr_row_o` takes the internal counter, `addr_i` is ignored, and the cycle reports type 6.
- R4: During a column-before-row refresh no array access takes place, and `dout_o` and `dout_en_o` keep the values they had from the previous cycle.
- R5: The refresh counter increments by one at the end of each column-before-row refresh and wraps from 1023 to 0.
- R6: The column is taken from `addr_i` at the fall of `cas_ni`. Address changes while `cas_ni` stays low do not move a later write.
- R7: A fall of `cas_ni` while `ras_ni` is high writes nothing and drives no output. The rise of `cas_ni` then reports type 7.
- R8: If `we_ni` is low when `cas_ni` falls, `din_i` is stored at that moment and `dout_en_o` stays 0 for the whole access, whatever `oe_ni` does. The cycle reports type 2.
- R9: A fall of `we_ni` during a read access stores `din_i` at the captured column at that moment, and `dout_en_o` then follows the inverse of `oe_ni`. The cycle reports type 4 if the output was enabled before the write, and type 3 if it was not.
- R10: In a read, `dout_o` shows the stored byte and `dout_en_o` equals the inverse of `oe_ni` while the I/O path is on. The path stays on until both `cas_ni` and `ras_ni` are high.
- R11: Several column cycles under one low `ras_ni` each access their own column of the retained row. Reads and early writes can be mixed in that sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Multiplexed row/column address |
| din_i | input | DATA_W | Write data |
| dout_o | output | DATA_W | Read data latch |
| dout_en_o | output | 1 | Output driver enable (0 = high impedance) |
| refr_stb_o | output | 1 | One-cycle pulse: a row was refreshed |
| refr_row_o | output | ADDR_W | Row refreshed with the last pulse |
| cyc_done_o | output | 1 | One-cycle pulse at the end of a cycle |
| cyc_type_o | output | 3 | Type code of the cycle that just ended |

## Verification
Two functions can fall in the same cycle: the output drive of a finished read, and a column-before-row refresh. The bench provokes this with a hidden refresh. It keeps `cas_ni` low after the read, raises `ras_ni`, then lowers it again with a new value on `addr_i`. It judges the result by two checks: `dout_o` and `dout_en_o` must stay at the read's values through the refresh, and `refr_row_o` must show the counter and not the address. A second overlap is a late write and the output enable. Here `oe_ni` is toggled after `we_ni` falls, and the captured column must be the one written.

// File: rtl/dram_cyc_pkg.sv
package dram_cyc_pkg;
  typedef enum logic [2:0] {
    CYC_NONE     = 3'd0,
    CYC_READ     = 3'd1,
    CYC_EARLY_WR = 3'd2,
    CYC_LATE_WR  = 3'd3,
    CYC_RMW      = 3'd4,
    CYC_RAS_ONLY = 3'd5,
    CYC_CBR      = 3'd6,
    CYC_CAS_ONLY = 3'd7
  } cyc_e;
endpackage

// File: rtl/dram_rfsh_ctr.sv
module dram_rfsh_ctr #(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inc_i,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  // R5
  ctr_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && cnt_q == '1) |=> (cnt_q == '0));
endmodule

// File: rtl/dram_cell_store.sv
module dram_cell_store #(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/dram_strobe_ctl.sv
module dram_strobe_ctl
  import dram_cyc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int ROW_AW = 3,
  parameter int COL_AW = 3,
  localparam int ARR_AW = ROW_AW + COL_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] rfsh_cnt_i,
  output logic              rfsh_inc_o,
  output logic              wr_en_o,
  output logic [ARR_AW-1:0] wr_addr_o,
  output logic              rd_stb_o,
  output logic [ARR_AW-1:0] rd_addr_o,
  output logic              io_on_o,
  output logic              early_o,
  output logic              cbr_o,
  output logic              refr_stb_o,
  output logic [ADDR_W-1:0] refr_row_o,
  output logic              cyc_done_o,
  output cyc_e              cyc_type_o
);
  logic ras_q, cas_q, we_q;
  logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
  logic acc_ok, cas_acc, late_we;

  logic              cbr_q, acc_seen_q, io_on_q, early_q, drove_q, cas_only_q;
  cyc_e              acc_typ_q, cyc_type_q;
  logic [ROW_AW-1:0] row_q;
  logic [COL_AW-1:0] col_q;
  logic              refr_stb_q, done_q;
  logic [ADDR_W-1:0] refr_row_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      we_q  <= 1'b1;
    end else begin
      ras_q <= ras_ni;
      cas_q <= cas_ni;
      we_q  <= we_ni;
    end
  end

  assign ras_fall = ras_q & ~ras_ni;
  assign ras_rise = ~ras_q & ras_ni;
  assign cas_fall = cas_q & ~cas_ni;
  assign cas_rise = ~cas_q & cas_ni;
  assign we_fall  = we_q & ~we_ni;

  // normal access only once the row strobe is settled low
  assign acc_ok  = ~ras_q & ~ras_ni & ~cbr_q;
  assign cas_acc = cas_fall & acc_ok;
  assign late_we = we_fall & ~cas_q & ~cas_ni & acc_ok & io_on_q & ~early_q;

  assign wr_en_o   = (cas_acc & ~we_ni) | late_we;
  assign wr_addr_o = {row_q, cas_acc ? addr_i[COL_AW-1:0] : col_q};
  assign rd_stb_o  = cas_acc & we_ni;
  assign rd_addr_o = {row_q, addr_i[COL_AW-1:0]};
  assign rfsh_inc_o = ras_rise & cbr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cbr_q      <= 1'b0;
      acc_seen_q <= 1'b0;
      io_on_q    <= 1'b0;
      early_q    <= 1'b0;
      drove_q    <= 1'b0;
      cas_only_q <= 1'b0;
      acc_typ_q  <= CYC_NONE;
      cyc_type_q <= CYC_NONE;
      row_q      <= '0;
      col_q      <= '0;
      refr_stb_q <= 1'b0;
      refr_row_q <= '0;
      done_q     <= 1'b0;
    end else begin
      refr_stb_q <= 1'b0;
      done_q     <= 1'b0;

      if (ras_fall) begin
        refr_stb_q <= 1'b1;
        acc_seen_q <= 1'b0;
        cas_only_q <= 1'b0;
        if (!cas_ni) begin
          cbr_q      <= 1'b1;
          refr_row_q <= rfsh_cnt_i;
        end else begin
          cbr_q      <= 1'b0;
          row_q      <= addr_i[ROW_AW-1:0];
          refr_row_q <= addr_i;
        end
      end

      if (ras_rise) begin
        done_q     <= 1'b1;
        cyc_type_q <= cbr_q ? CYC_CBR : (acc_seen_q ? acc_typ_q : CYC_RAS_ONLY);
        cbr_q      <= 1'b0;
      end

      if (cas_acc) begin
        col_q      <= addr_i[COL_AW-1:0];
        acc_seen_q <= 1'b1;
        io_on_q    <= 1'b1;
        early_q    <= ~we_ni;
        drove_q    <= ~oe_ni & we_ni;
        acc_typ_q  <= we_ni ? CYC_READ : CYC_EARLY_WR;
      end else if (io_on_q && ras_ni && cas_ni) begin
        io_on_q <= 1'b0;  // later of the two strobe rises
      end else if (io_on_q && !early_q && !oe_ni) begin
        drove_q <= 1'b1;
      end

      if (late_we) acc_typ_q <= drove_q ? CYC_RMW : CYC_LATE_WR;

      if (cas_fall && ras_q && ras_ni) cas_only_q <= 1'b1;
      if (cas_rise && cas_only_q && ras_ni) begin
        cas_only_q <= 1'b0;
        done_q     <= 1'b1;
        cyc_type_q <= CYC_CAS_ONLY;
      end
    end
  end

  assign io_on_o    = io_on_q;
  assign early_o    = early_q;
  assign cbr_o      = cbr_q;
  assign refr_stb_o = refr_stb_q;
  assign refr_row_o = refr_row_q;
  assign cyc_done_o = done_q;
  assign cyc_type_o = cyc_type_q;

  // R7
  cas_only_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ras_q && ras_ni) |-> (!wr_en_o && !rd_stb_o));

  // R4
  cbr_no_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cbr_q |-> (!wr_en_o && !rd_stb_o));

  // R2
  refr_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refr_stb_q |-> ($past(ras_q) && !$past(ras_ni)));
endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dram_cyc_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8,
  parameter int ROW_AW = 3,
  parameter int COL_AW = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ras_ni,
  input  logic              cas_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o,
  output logic              refr_stb_o,
  output logic [ADDR_W-1:0] refr_row_o,
  output logic              cyc_done_o,
  output logic [2:0]        cyc_type_o
);
  localparam int ARR_AW = ROW_AW + COL_AW;

  logic [ADDR_W-1:0] rfsh_cnt;
  logic              rfsh_inc, wr_en, rd_stb, io_on, early, cbr;
  logic [ARR_AW-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] rd_data, dout_q;
  cyc_e              cyc_type;

  dram_rfsh_ctr #(.CW(ADDR_W)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (rfsh_inc),
    .cnt_o (rfsh_cnt)
  );

  dram_strobe_ctl #(.ADDR_W(ADDR_W), .ROW_AW(ROW_AW), .COL_AW(COL_AW)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ras_ni    (ras_ni),
    .cas_ni    (cas_ni),
    .we_ni     (we_ni),
    .oe_ni     (oe_ni),
    .addr_i    (addr_i),
    .rfsh_cnt_i(rfsh_cnt),
    .rfsh_inc_o(rfsh_inc),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_stb_o  (rd_stb),
    .rd_addr_o (rd_addr),
    .io_on_o   (io_on),
    .early_o   (early),
    .cbr_o     (cbr),
    .refr_stb_o(refr_stb_o),
    .refr_row_o(refr_row_o),
    .cyc_done_o(cyc_done_o),
    .cyc_type_o(cyc_type)
  );

  dram_cell_store #(.AW(ARR_AW), .DW(DATA_W)) u_store (
    .clk_i    (clk_i),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(din_i),
    .rd_addr_i(rd_addr),
    .rd_data_o(rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dout_q <= '0;
    else if (rd_stb) dout_q <= rd_data;
  end

  assign dout_o     = dout_q;
  assign dout_en_o  = io_on & ~early & ~oe_ni;
  assign cyc_type_o = cyc_type;

  // R4
  cbr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cbr && $past(cbr)) |-> $stable(dout_o));
endmodule

// File: tb/dram_cycle_decoder_tb_top.sv
module dram_cycle_decoder_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [9:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_en, refr_stb, cyc_done;
  logic [9:0] refr_row;
  logic [2:0] cyc_type;

  int n_chk = 0, n_bad = 0;
  int cbr_cnt = 0;
  logic [7:0] mem_m [64];

  always #2 clk = ~clk;

  dram_cycle_decoder dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ras_ni(ras_n), .cas_ni(cas_n), .we_ni(we_n),
    .oe_ni(oe_n), .addr_i(addr), .din_i(din), .dout_o(dout), .dout_en_o(dout_en),
    .refr_stb_o(refr_stb), .refr_row_o(refr_row), .cyc_done_o(cyc_done),
    .cyc_type_o(cyc_type)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic int ix(input logic [9:0] row, input logic [9:0] col);
    return {26'd0, row[2:0], col[2:0]};
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset();
    chk("R1 dout_en", dout_en, 0);
    chk("R1 refr_stb", refr_stb, 0);
    chk("R1 cyc_done", cyc_done, 0);
  endtask

  task automatic t_ras_only(input logic [9:0] row);
    addr = row; ras_n = 0; cyc();
    chk("R2 refr_stb", refr_stb, 1);
    chk("R2 refr_row", refr_row, row);
    ras_n = 1; cyc();
    chk("R2 done", cyc_done, 1);
    chk("R2 type", cyc_type, 5);
    cyc();
    chk("R2 pulse ends", refr_stb | cyc_done, 0);
  endtask

  task automatic t_early_write(input logic [9:0] row, input logic [9:0] col, input logic [7:0] d);
    addr = row; ras_n = 0; cyc();
    addr = col; din = d; we_n = 0; oe_n = 0; cyc();
    cas_n = 0; cyc();
    chk("R8 hiz", dout_en, 0);
    cyc();
    chk("R8 hiz hold", dout_en, 0);
    cas_n = 1; we_n = 1; oe_n = 1; ras_n = 1; cyc();
    chk("R8 type", cyc_type, 2);
    mem_m[ix(row, col)] = d;
  endtask

  task automatic t_read(input logic [9:0] row, input logic [9:0] col);
    addr = row; ras_n = 0; cyc();
    addr = col; oe_n = 0; cas_n = 0; cyc();
    chk("R10 en", dout_en, 1);
    chk("R10 data", dout, mem_m[ix(row, col)]);
    ras_n = 1; cyc();
    chk("R10 en after ras rise", dout_en, 1);
    chk("R10 type", cyc_type, 1);
    cas_n = 1; cyc();
    chk("R10 off", dout_en, 0);
    oe_n = 1;
  endtask

  task automatic t_late_write(input logic [9:0] row, input logic [9:0] col,
                              input logic [7:0] d, input bit rmw);
    logic [7:0] old;
    old = mem_m[ix(row, col)];
    addr = row; ras_n = 0; cyc();
    addr = col; oe_n = rmw ? 1'b0 : 1'b1; cas_n = 0; cyc();
    if (rmw) chk("R9 rmw read", dout, old);
    else     chk("R9 oe high hiz", dout_en, 0);
    addr = col ^ 10'd1; din = d; oe_n = 1; we_n = 0; cyc();
    chk("R9 hiz after we", dout_en, 0);
    oe_n = 0; cyc();
    chk("R9 oe governs", dout_en, 1);
    if (rmw) chk("R9 rmw old data", dout, old);
    oe_n = 1; we_n = 1; cas_n = 1; ras_n = 1; cyc();
    chk("R9 type", cyc_type, rmw ? 4 : 3);
    mem_m[ix(row, col)] = d;
  endtask

  task automatic t_fast_page(input logic [9:0] row);
    addr = row; ras_n = 0; cyc();
    for (int i = 0; i < 4; i++) begin
      addr = 10'(i * 3); oe_n = 0;
      if (i == 2) begin din = 8'hC7; we_n = 0; end
      cas_n = 0; cyc();
      if (i == 2) begin
        chk("R11 early in page", dout_en, 0);
        mem_m[ix(row, 10'(i * 3))] = 8'hC7;
      end else begin
        chk("R11 page data", dout, mem_m[ix(row, 10'(i * 3))]);
      end
      cas_n = 1; we_n = 1; cyc();
    end
    addr = 10'd6; cas_n = 0; cyc();
    chk("R11 reread written col", dout, 8'hC7);
    cas_n = 1; ras_n = 1; oe_n = 1; cyc();
    chk("R11 type", cyc_type, 1);
  endtask

  task automatic t_cas_only(input logic [9:0] row, input logic [9:0] col);
    addr = col; din = ~mem_m[ix(row, col)]; we_n = 0; oe_n = 0; cas_n = 0; cyc();
    chk("R7 no drive", dout_en, 0);
    cas_n = 1; we_n = 1; oe_n = 1; cyc();
    chk("R7 done", cyc_done, 1);
    chk("R7 type", cyc_type, 7);
    t_read(row, col);  // unchanged contents
  endtask

  task automatic t_cbr(input bit check);
    cas_n = 0; cyc();
    addr = 10'h155; ras_n = 0; cyc();
    if (check) chk("R3 cbr row", refr_row, cbr_cnt);
    ras_n = 1; cas_n = 1; cyc();
    if (check) chk("R3 type", cyc_type, 6);
    cbr_cnt = (cbr_cnt + 1) % 1024;
  endtask

  task automatic t_hidden_cbr(input logic [9:0] row, input logic [9:0] col);
    logic [7:0] exp;
    exp = mem_m[ix(row, col)];
    addr = row; ras_n = 0; cyc();
    addr = col; oe_n = 0; cas_n = 0; cyc();
    ras_n = 1; cyc();
    addr = 10'h2AB; din = 8'h00; ras_n = 0; cyc();
    chk("R3 stb", refr_stb, 1);
    chk("R3 addr ignored", refr_row, cbr_cnt);
    chk("R4 data held", dout, exp);
    chk("R4 en held", dout_en, 1);
    cyc();
    chk("R4 data held 2", dout, exp);
    ras_n = 1; cyc();
    chk("R3 hidden type", cyc_type, 6);
    cbr_cnt = (cbr_cnt + 1) % 1024;
    cas_n = 1; oe_n = 1; cyc();
    chk("R10 off after cas", dout_en, 0);
  endtask

  task automatic t_cbr_wrap();
    while (cbr_cnt != 1023) t_cbr(0);
    t_cbr(1);
    chk("R5 wrapped", cbr_cnt, 0);
    t_cbr(1);  // must report row 0 again
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    cyc(); cyc();
    t_reset();
    rst_n = 1; cyc();
    t_reset();
    for (int c = 0; c < 8; c++) t_early_write(10'h3C2, 10'(c), 8'(8'h10 + c * 7));
    t_early_write(10'h005, 10'h001, 8'h5A);
    t_ras_only(10'h2F1);
    t_read(10'h3C2, 10'd3);
    t_read(10'h005, 10'd1);
    t_late_write(10'h3C2, 10'd4, 8'hA5, 0);
    t_read(10'h3C2, 10'd4);
    t_read(10'h3C2, 10'd5);  // R6 neighbour untouched
    t_late_write(10'h3C2, 10'd2, 8'h3E, 1);
    t_read(10'h3C2, 10'd2);
    t_fast_page(10'h3C2);
    t_cas_only(10'h3C2, 10'd7);
    t_cbr(1);                // R1 counter starts at 0
    t_hidden_cbr(10'h005, 10'd1);
    t_cbr_wrap();
    summary();
  end
endmodule